// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is one pulse-width-modulation timer channel. It is advanced by a tick enable that has already been divided down from the system clock elsewhere. Software programs a period value and a compare value into two holding registers. Neither value reaches the running counter until a manual-update strobe copies both at once, or until the counter auto-reloads them as it expires. The counter counts down. The raw waveform rises when the counter reaches the compare value and falls again at the next reload. An inverter stage, enabled out of reset, sits in front of the output pin.

The expected bring-up order has two steps. First, load the holding registers and pulse the update strobe with the run control low. Then raise run and auto-reload together. If auto-reload is dropped while the channel runs, the channel finishes its current period and parks. A compare value of all ones never matches, so with the inverter enabled the pin stays high for the whole period. A manual update is the way to pull the waveform back to its reload level once the channel has parked holding the other level.

Top module: `dbpwm_channel`

## Requirements
- R1: After reset the holding registers, the active count, the active compare and the raw waveform are zero, the inverter is enabled, `pwm_out` is 1 and `expire_pulse` is 0.
- R2: A write to either holding register does not change the period in progress. The new values apply only from the next reload or manual update.
- R3: While `man_upd` is 1, every clock copies both holding registers into the active count and compare, forces the raw waveform low and produces no expiry. Counting resumes with the loaded value once `man_upd` returns to 0.
- R4: A count value N gives a period of N+1 ticks. On the clock after a tick that finds the counter at zero, `expire_pulse` is 1 for exactly one clock.
- R5: The raw waveform is low from a reload until a tick decrements the counter to the compare value C, and high from then until the next reload. With the inverter enabled, `pwm_out` is therefore high for N−C ticks of each period.
- R6: A compare value of all ones (counter width bits) never matches, so the raw waveform stays low and, with the inverter enabled, `pwm_out` is high for the whole period.
- R7: When the counter expires with `auto_rld` at 0, one expiry pulse is produced, the counter parks at zero and `pwm_out` keeps its level. No further ticks have any effect until a manual update.
- R8: A manual update on a parked channel whose raw waveform is high drives the raw waveform low. The pin returns to the reload level one clock later, and a full period of N+1 ticks follows.
- R9: While `start` is 0, or on clocks without `tick_en`, the counter, the waveform and the expiry pulse hold. With a tick every K clocks, one period lasts K·(N+1) clocks.
- R10: Writing `inv_wdata` with `inv_we` at 1 sets the inverter. With the inverter at 0, `pwm_out` equals the raw waveform and is high for C+1 ticks of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Divided tick; one counter step per clock where it is 1 |
| cnt_buf_we | input | 1 | Write strobe for the period holding register |
| cnt_buf_wdata | input | CNT_W | Period value N (period is N+1 ticks) |
| cmp_buf_we | input | 1 | Write strobe for the compare holding register |
| cmp_buf_wdata | input | CNT_W | Compare value C |
| start | input | 1 | Run control; counter holds while 0 |
| man_upd | input | 1 | Manual update: copy holding registers into the active counter |
| auto_rld | input | 1 | Reload from holding registers at expiry instead of parking |
| inv_we | input | 1 | Write strobe for the inverter control |
| inv_wdata | input | 1 | Inverter value; 1 inverts the raw waveform |
| pwm_out | output | 1 | Output pin after the inverter |
| expire_pulse | output | 1 | One-clock pulse after each expiry |

## Verification
Several properties are checked on every clock. A manual update copies both holding registers. The active compare changes only on a load. The counter and compare freeze while the run control is low. A parked channel stays parked. An all-ones compare never produces a match. A load clears the raw waveform, a match sets it, and parking leaves it alone. Period lengths, high-time counts, the deferral of holding-register writes to the next reload, the recovery from a parked-high state, sparse tick spacing and polarity can only be shown by the bench scenarios, which measure whole periods between expiry pulses.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;

   // Action the down-counter takes on a given clock
   typedef enum logic [2:0] {
      CA_IDLE,   // hold
      CA_LOAD,   // manual update from holding registers
      CA_STEP,   // decrement on a tick
      CA_WRAP,   // expiry with auto-reload
      CA_STOP    // expiry without auto-reload: park
   } cnt_act_e;

   // Counter widths the channel supports
   function automatic bit width_ok(input int w);
      return (w == 16) || (w == 32);
   endfunction

endpackage

// File: rtl/dbpwm_shadow.sv
module dbpwm_shadow #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             cmp_we,
   input  logic [CNT_W-1:0] cmp_wdata,
   output logic [CNT_W-1:0] cnt_buf,
   output logic [CNT_W-1:0] cmp_buf
);

   localparam int NBUF = 2;   // index 0: period, index 1: compare

   logic [NBUF-1:0]            we_v;
   logic [NBUF-1:0][CNT_W-1:0] wd_v;
   logic [NBUF-1:0][CNT_W-1:0] buf_q;

   always_comb begin
      we_v[0] = cnt_we;
      we_v[1] = cmp_we;
      wd_v[0] = cnt_wdata;
      wd_v[1] = cmp_wdata;
   end

   for (genvar i = 0; i < NBUF; i++) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       buf_q[i] <= '0;
         else if (we_v[i]) buf_q[i] <= wd_v[i];
      end
   end

   assign cnt_buf = buf_q[0];
   assign cmp_buf = buf_q[1];

   AST_PERIOD_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_we |=> $stable(cnt_buf)); // R2
   AST_CMP_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_we |=> $stable(cmp_buf)); // R2

endmodule

// File: rtl/dbpwm_counter.sv
module dbpwm_counter
   import dbpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             start,
   input  logic             man_upd,
   input  logic             auto_rld,
   input  logic [CNT_W-1:0] cnt_buf,
   input  logic [CNT_W-1:0] cmp_buf,
   output logic             load_ev,
   output logic             match_ev,
   output logic             halt_ev,
   output logic             expire_pulse
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] ALL1 = '1;

   logic [CNT_W-1:0] cnt_q, cmp_q, cnt_dec;
   logic             halt_q, expire_q;
   cnt_act_e         act;

   assign cnt_dec = cnt_q - ONE;

   always_comb begin
      act = CA_IDLE;
      if (man_upd) begin
         act = CA_LOAD;
      end else if (start && tick_en && !halt_q) begin
         if (cnt_q == ZERO) act = auto_rld ? CA_WRAP : CA_STOP;
         else               act = CA_STEP;
      end
   end

   assign load_ev  = (act == CA_LOAD) || (act == CA_WRAP);
   assign match_ev = (act == CA_STEP) && (cnt_dec == cmp_q);
   assign halt_ev  = (act == CA_STOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         cmp_q    <= '0;
         halt_q   <= 1'b0;
         expire_q <= 1'b0;
      end else begin
         expire_q <= (act == CA_WRAP) || (act == CA_STOP);
         case (act)
            CA_LOAD, CA_WRAP: begin
               cnt_q  <= cnt_buf;
               cmp_q  <= cmp_buf;
               halt_q <= 1'b0;
            end
            CA_STEP: cnt_q  <= cnt_dec;
            CA_STOP: halt_q <= 1'b1;
            default: ;
         endcase
      end
   end

   assign expire_pulse = expire_q;

   AST_UPDATE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      man_upd |=> (cnt_q == $past(cnt_buf)) && (cmp_q == $past(cmp_buf))); // R3
   AST_CMP_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_ev |=> $stable(cmp_q)); // R2
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !man_upd) |=> ($stable(cnt_q) && !expire_pulse)); // R9
   AST_PARKED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !man_upd) |=> (halt_q && $stable(cnt_q) && !expire_pulse)); // R7
   AST_FULL_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_q == ALL1) |-> !match_ev); // R6
   AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      expire_pulse |-> ($past(cnt_q) == ZERO)); // R4

endmodule

// File: rtl/dbpwm_outstage.sv
module dbpwm_outstage #(
   parameter bit INV_RST = 1'b1,
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_ev,
   input  logic match_ev,
   input  logic halt_ev,
   input  logic inv_we,
   input  logic inv_wdata,
   output logic pwm_out
);

   logic raw_q, inv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
         inv_q <= INV_RST;
      end else begin
         if (load_ev)                   raw_q <= 1'b0;
         else if (match_ev && !halt_ev) raw_q <= 1'b1;
         if (inv_we) inv_q <= inv_wdata;
      end
   end

   if (REG_OUT) begin : g_reg_pin
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q <= INV_RST;
         else        pin_q <= raw_q ^ inv_q;
      end
      assign pwm_out = pin_q;
   end else begin : g_comb_pin
      assign pwm_out = raw_q ^ inv_q;
   end

   AST_LOAD_CLEARS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      load_ev |=> !raw_q); // R3
   AST_MATCH_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (match_ev && !load_ev) |=> raw_q); // R5
   AST_PARK_KEEPS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      halt_ev |=> $stable(raw_q)); // R7
   AST_INV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      inv_we |=> (inv_q == $past(inv_wdata))); // R10

endmodule

// File: rtl/dbpwm_channel.sv
module dbpwm_channel
   import dbpwm_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit INV_RST = 1'b1,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             cnt_buf_we,
   input  logic [CNT_W-1:0] cnt_buf_wdata,
   input  logic             cmp_buf_we,
   input  logic [CNT_W-1:0] cmp_buf_wdata,
   input  logic             start,
   input  logic             man_upd,
   input  logic             auto_rld,
   input  logic             inv_we,
   input  logic             inv_wdata,
   output logic             pwm_out,
   output logic             expire_pulse
);

   // R6: the all-ones compare is tied to this width
   if (!width_ok(CNT_W)) begin : g_bad_width
      $error("dbpwm_channel: CNT_W must be 16 or 32");
   end

   logic [CNT_W-1:0] cnt_buf, cmp_buf;
   logic             load_ev, match_ev, halt_ev;

   dbpwm_shadow #(.CNT_W(CNT_W)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_we    (cnt_buf_we),
      .cnt_wdata (cnt_buf_wdata),
      .cmp_we    (cmp_buf_we),
      .cmp_wdata (cmp_buf_wdata),
      .cnt_buf   (cnt_buf),
      .cmp_buf   (cmp_buf)
   );

   dbpwm_counter #(.CNT_W(CNT_W)) u_counter (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_en      (tick_en),
      .start        (start),
      .man_upd      (man_upd),
      .auto_rld     (auto_rld),
      .cnt_buf      (cnt_buf),
      .cmp_buf      (cmp_buf),
      .load_ev      (load_ev),
      .match_ev     (match_ev),
      .halt_ev      (halt_ev),
      .expire_pulse (expire_pulse)
   );

   dbpwm_outstage #(.INV_RST(INV_RST), .REG_OUT(REG_OUT)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_ev   (load_ev),
      .match_ev  (match_ev),
      .halt_ev   (halt_ev),
      .inv_we    (inv_we),
      .inv_wdata (inv_wdata),
      .pwm_out   (pwm_out)
   );

   AST_MATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({load_ev, match_ev, halt_ev}) <= 1); // R5

endmodule

// File: tb/dbpwm_channel_tb.sv
`timescale 1ns/1ps
module dbpwm_channel_tb;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick_en = 1'b0;
   logic             cnt_buf_we = 1'b0;
   logic [CNT_W-1:0] cnt_buf_wdata = '0;
   logic             cmp_buf_we = 1'b0;
   logic [CNT_W-1:0] cmp_buf_wdata = '0;
   logic             start = 1'b0;
   logic             man_upd = 1'b0;
   logic             auto_rld = 1'b0;
   logic             inv_we = 1'b0;
   logic             inv_wdata = 1'b0;
   logic             pwm_out;
   logic             expire_pulse;

   int tests = 0;
   int fails = 0;
   int tick_div = 1;
   int tick_ph = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dbpwm_channel #(.CNT_W(CNT_W)) u_dut (
      .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
      .cnt_buf_we (cnt_buf_we), .cnt_buf_wdata (cnt_buf_wdata),
      .cmp_buf_we (cmp_buf_we), .cmp_buf_wdata (cmp_buf_wdata),
      .start (start), .man_upd (man_upd), .auto_rld (auto_rld),
      .inv_we (inv_we), .inv_wdata (inv_wdata),
      .pwm_out (pwm_out), .expire_pulse (expire_pulse)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // advance to the next falling edge; the divided tick is driven here
   task automatic step();
      @(negedge clk);
      tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
      tick_en = (tick_ph == 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; start = 0; man_upd = 0; auto_rld = 0;
      cnt_buf_we = 0; cmp_buf_we = 0; inv_we = 0; tick_div = 1; tick_ph = 0;
      step(); step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic write_bufs(input int n, input int c);
      cnt_buf_we = 1; cnt_buf_wdata = CNT_W'(n);
      cmp_buf_we = 1; cmp_buf_wdata = CNT_W'(c);
      step();
      cnt_buf_we = 0; cmp_buf_we = 0;
   endtask

   task automatic load(input int n, input int c);
      write_bufs(n, c);
      man_upd = 1;
      step();
      man_upd = 0;
   endtask

   task automatic wait_pulse(output int waited);
      waited = 0;
      do begin
         step();
         waited++;
      end while (!expire_pulse && waited < 2000);
   endtask

   // call on a sample where expire_pulse is 1; counts clocks to the next one
   task automatic measure(output int period, output int hi);
      period = 0; hi = 0;
      do begin
         if (pwm_out) hi++;
         period++;
         step();
      end while (!expire_pulse && period < 2000);
   endtask

   task automatic t_reset();
      do_reset();
      chk(pwm_out == 1'b1, "R1 pin after reset", pwm_out, 1);
      chk(expire_pulse == 1'b0, "R1 no expiry after reset", expire_pulse, 0);
      chk(pwm_out == 1'b1, "R10 inverter enabled at reset", pwm_out, 1);
   endtask

   task automatic t_basic();
      int w, p, h;
      do_reset();
      load(4, 1);
      start = 1; auto_rld = 1;
      wait_pulse(w);
      chk(w == 5, "R4 first expiry after N+1 ticks", w, 5);
      measure(p, h);
      chk(p == 5, "R4 period N=4", p, 5);
      chk(h == 3, "R5 high ticks N-C", h, 3);
      load(7, 5);
      wait_pulse(w);
      chk(w == 8, "R4 expiry after reload N=7", w, 8);
      measure(p, h);
      chk(p == 8, "R4 period N=7", p, 8);
      chk(h == 2, "R5 high ticks N=7 C=5", h, 2);
   endtask

   task automatic t_defer();
      int w, p, h;
      do_reset();
      load(4, 1);
      start = 1; auto_rld = 1;
      wait_pulse(w);
      write_bufs(9, 2);
      wait_pulse(w);
      chk(w == 4, "R2 current period unchanged by write", w, 4);
      measure(p, h);
      chk(p == 10, "R2 new period after reload", p, 10);
      chk(h == 7, "R2 new high time after reload", h, 7);
   endtask

   task automatic t_full();
      int w, p, h;
      do_reset();
      load(3, 32'hFFFF);
      start = 1; auto_rld = 1;
      wait_pulse(w);
      measure(p, h);
      chk(p == 4, "R6 period with all-ones compare", p, 4);
      chk(h == 4, "R6 pin high whole period", h, 4);
   endtask

   task automatic t_manual();
      int w;
      bit saw_pulse = 0, saw_low = 0;
      do_reset();
      load(4, 1);
      start = 1; auto_rld = 1;
      man_upd = 1;
      for (int i = 0; i < 6; i++) begin
         step();
         if (expire_pulse) saw_pulse = 1;
         if (!pwm_out) saw_low = 1;
      end
      chk(!saw_pulse, "R3 no expiry while update held", saw_pulse, 0);
      chk(!saw_low, "R3 raw held low while update held", saw_low, 0);
      man_upd = 0;
      wait_pulse(w);
      chk(w == 5, "R3 count resumes from loaded value", w, 5);
   endtask

   task automatic t_stop();
      int w, npulse;
      bit moved;
      do_reset();
      load(4, 1);
      start = 1; auto_rld = 1;
      wait_pulse(w);
      auto_rld = 0;
      wait_pulse(w);
      chk(w == 5, "R7 current period completes", w, 5);
      chk(pwm_out == 1'b0, "R7 level held at park", pwm_out, 0);
      npulse = 0; moved = 0;
      for (int i = 0; i < 20; i++) begin
         step();
         if (expire_pulse) npulse++;
         if (pwm_out !== 1'b0) moved = 1;
      end
      chk(npulse == 0, "R7 no expiry while parked", npulse, 0);
      chk(!moved, "R7 pin steady while parked", moved, 0);
      man_upd = 1;
      step();
      man_upd = 0;
      chk(pwm_out == 1'b1, "R8 update drives pin to reload level", pwm_out, 1);
      wait_pulse(w);
      chk(w == 5, "R8 full period after forced update", w, 5);
   endtask

   task automatic t_hold();
      int w, p, h;
      bit moved = 0, pulsed = 0;
      logic lvl;
      do_reset();
      load(4, 1);
      start = 1; auto_rld = 1;
      wait_pulse(w);
      step(); step();
      start = 0;
      step();
      lvl = pwm_out;
      for (int i = 0; i < 10; i++) begin
         step();
         if (pwm_out !== lvl) moved = 1;
         if (expire_pulse) pulsed = 1;
      end
      chk(!moved, "R9 pin holds with start low", moved, 0);
      chk(!pulsed, "R9 no expiry with start low", pulsed, 0);
      start = 1;
      wait_pulse(w);
      chk(w == 3, "R9 count resumes where it stopped", w, 3);
      tick_div = 3;
      wait_pulse(w);
      measure(p, h);
      chk(p == 15, "R9 period with tick every 3 clocks", p, 15);
      chk(h == 9, "R9 high time with sparse ticks", h, 9);
   endtask

   task automatic t_invert();
      int w, p, h;
      do_reset();
      load(4, 1);
      inv_we = 1; inv_wdata = 0;
      step();
      inv_we = 0;
      chk(pwm_out == 1'b0, "R10 raw level shown when not inverted", pwm_out, 0);
      start = 1; auto_rld = 1;
      wait_pulse(w);
      measure(p, h);
      chk(p == 5, "R10 period unaffected by polarity", p, 5);
      chk(h == 2, "R10 high ticks C+1 without inversion", h, 2);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_defer();
      t_full();
      t_manual();
      t_stop();
      t_hold();
      t_invert();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule